// File: doc/BRIEF.md
# Microcode Sequencer with Scan Patch

This block is a microprogrammed control unit. A read-only control store holds one encoded microinstruction per address. Each word has a control field, a dispatch flag, a two-bit condition selector and a partial next address. The word fetched each cycle lands in a microinstruction register. That register drives the control-field output, and its fields build the address of the following fetch from the condition inputs, or from the opcode when dispatch is set.

The same microinstruction register also serves as a serial test data register. A shift stage driven by capture, shift and update strobes reaches three targets: the microinstruction register, a patch-address register and a patch-data register. The strobes follow the data-register phases of a boundary-scan controller, all in the functional clock domain. Test logic can read the running microinstruction or force a new one for a single step. One control-store word can also be swapped for a scan-loaded replacement: whenever a fetch address equals the armed patch address, the patch word is loaded in place of the stored one.

Top module: `useq_scan_patch`

## Requirements
- R1: While `rst` is high (synchronous, active high), `upc`, `ctrl` and `scan_out` read zero and the patch is disarmed. The first edge after release fetches address 0.
- R2: The stored word at address a is {ctrl = {a, a[2:0] xor 3'b101} (13 bits, bits 23:11), dispatch = a[5]&a[4]&a[3]&a[2] (bit 10), selector = a[3:2] (bits 9:8), next field = a[9:2]+1 (bits 7:0)}. `ctrl` shows bits 23:11 of the microinstruction register, and `upc` shows the address it came from.
- R3: When dispatch is clear, the next address is {next field, c}. The selector picks c: 00 gives 2'b00, 01 gives {0, cond[0]}, 10 gives cond[1:0], and 11 gives cond[3:2].
- R4: When dispatch is set, the next address is {2'b11, opcode}.
- R5: Select codes are 0 for the microinstruction register (24 bits), 1 for the patch address {valid in bit 10, address in bits 9:0} (11 bits), 2 for the patch data (24 bits), and 3 for a 1-bit bypass that captures 0. Capture loads the selected value into the shift stage. Shift moves it one bit per clock toward `scan_out` (bit 0 of the stage), LSB first, with `scan_in` entering at the top bit of the selected length. Capture has priority over shift, and shift has priority over update.
- R6: An update with select 0 loads the shift stage into the microinstruction register and holds `upc` for that cycle. The injected word is active for exactly one cycle, and its own fields form the next address.
- R7: With the patch armed, a fetch whose address equals the patch address loads the patch-data word instead of the stored word.
- R8: Capture and shift do not disturb the sequence of fetches.
- R9: Reset disarms the patch, so a later fetch of the former patch address returns the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sequencer and the scan strobes |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 8 | Current instruction opcode used by dispatch |
| cond | input | 4 | External condition flags |
| scan_sel | input | 2 | Scan target select |
| scan_capture | input | 1 | Load selected register into the shift stage |
| scan_shift | input | 1 | Shift the stage one bit toward scan_out |
| scan_update | input | 1 | Write the shift stage into the selected register |
| scan_in | input | 1 | Serial data in |
| scan_out | output | 1 | Serial data out, bit 0 of the shift stage |
| upc | output | 10 | Address of the current microinstruction |
| ctrl | output | 13 | Control field of the current microinstruction |

## Verification
The hardest situation to reach is a patch hit. The sequencer wanders by conditions and opcodes, so no fixed address is reached on a predictable cycle. The stimulus first scans in the patch data and an armed patch address of 0x080. It then injects a microinstruction whose next field is 0x20 with selector 00, which forces the very next fetch to 0x080. The same injection after a reset shows that the patch was disarmed.

// File: rtl/useq_scan_patch.sv
module useq_scan_patch #(
  parameter int OP_W   = 8,
  parameter int ADDR_W = 10,
  parameter int UI_W   = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [OP_W-1:0]          opcode,
  input  logic [3:0]               cond,
  input  logic [1:0]               scan_sel,
  input  logic                     scan_capture,
  input  logic                     scan_shift,
  input  logic                     scan_update,
  input  logic                     scan_in,
  output logic                     scan_out,
  output logic [ADDR_W-1:0]        upc,
  output logic [UI_W-ADDR_W-2:0]   ctrl
);
  localparam int NA_W     = ADDR_W - 2;
  localparam int SEL_LSB  = NA_W;
  localparam int DISP_B   = NA_W + 2;
  localparam int CTRL_LSB = NA_W + 3;
  localparam int CTRL_W   = UI_W - CTRL_LSB;
  localparam int PA_W     = ADDR_W + 1;
  localparam logic [1:0] SEL_UIR = 2'd0, SEL_PA = 2'd1, SEL_PD = 2'd2;

  function automatic logic [UI_W-1:0] rom_word(input logic [ADDR_W-1:0] a);
    logic [NA_W-1:0]   na;
    logic [CTRL_W-1:0] cf;
    na = a[ADDR_W-1:2] + 1'b1;
    cf = CTRL_W'({a, a[2:0] ^ 3'b101});
    return {cf, &a[5:2], a[3:2], na};
  endfunction

  logic [UI_W-1:0]   uir, sr, sr_shift, sr_cap, pdata, fetched;
  logic [ADDR_W-1:0] paddr, fetch_addr;
  logic              pvalid, boot, hit;
  logic [1:0]        cres;

  wire do_cap = scan_capture;
  wire do_sh  = scan_shift & ~scan_capture;
  wire do_upd = scan_update & ~scan_capture & ~scan_shift;
  wire hold   = do_upd && (scan_sel == SEL_UIR);
  wire [1:0] csel = uir[SEL_LSB +: 2];

  always_comb begin
    case (csel)
      2'd0:    cres = 2'b00;
      2'd1:    cres = {1'b0, cond[0]};
      2'd2:    cres = cond[1:0];
      default: cres = cond[3:2];
    endcase
  end

  assign fetch_addr = boot ? '0
                    : uir[DISP_B] ? {{(ADDR_W-OP_W){1'b1}}, opcode}
                    : {uir[NA_W-1:0], cres};
  assign hit     = pvalid && (fetch_addr == paddr);
  assign fetched = hit ? pdata : rom_word(fetch_addr);

  always_comb begin
    case (scan_sel)
      SEL_UIR: sr_cap = uir;
      SEL_PA:  sr_cap = UI_W'({pvalid, paddr});
      SEL_PD:  sr_cap = pdata;
      default: sr_cap = '0;
    endcase
  end

  always_comb begin
    sr_shift = '0;
    case (scan_sel)
      SEL_PA:  sr_shift[PA_W-1:0] = {scan_in, sr[PA_W-1:1]};
      2'd3:    sr_shift[0] = scan_in;
      default: sr_shift = {scan_in, sr[UI_W-1:1]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      boot   <= 1'b1;
      upc    <= '0;
      uir    <= '0;
      sr     <= '0;
      pvalid <= 1'b0;
      paddr  <= '0;
      pdata  <= '0;
    end else begin
      boot <= 1'b0;
      if (hold) begin
        uir <= sr;
      end else begin
        upc <= fetch_addr;
        uir <= fetched;
      end
      if (do_cap)     sr <= sr_cap;
      else if (do_sh) sr <= sr_shift;
      if (do_upd && scan_sel == SEL_PA) {pvalid, paddr} <= sr[PA_W-1:0];
      if (do_upd && scan_sel == SEL_PD) pdata <= sr;
    end
  end

  assign ctrl     = uir[UI_W-1:CTRL_LSB];
  assign scan_out = sr[0];

  p_boot_clear_r1: assert property (@(posedge clk) disable iff (rst)
    boot |-> (upc == '0) && !pvalid);
  p_uncond_r3: assert property (@(posedge clk) disable iff (rst)
    !hold && !boot && !uir[DISP_B] && csel == 2'd0 |=> upc[1:0] == 2'b00);
  p_dispatch_r4: assert property (@(posedge clk) disable iff (rst)
    !hold && !boot && uir[DISP_B] |=> upc == {{(ADDR_W-OP_W){1'b1}}, $past(opcode)});
  p_shift_out_r5: assert property (@(posedge clk) disable iff (rst)
    do_sh && scan_sel != 2'd3 |=> scan_out == $past(sr[1]));
  p_hold_pc_r6: assert property (@(posedge clk) disable iff (rst)
    hold |=> upc == $past(upc));
  p_inject_r6: assert property (@(posedge clk) disable iff (rst)
    hold |=> uir == $past(sr));
  p_patch_r7: assert property (@(posedge clk) disable iff (rst)
    !hold && pvalid && fetch_addr == paddr |=> uir == $past(pdata));
endmodule

// File: tb/tb_useq_scan_patch.sv
`timescale 1ns/1ps
module tb_useq_scan_patch;
  logic clk = 0, rst = 1;
  logic [7:0] opcode = 0;
  logic [3:0] cond = 0;
  logic [1:0] scan_sel = 0;
  logic scan_capture = 0, scan_shift = 0, scan_update = 0, scan_in = 0;
  logic scan_out;
  logic [9:0] upc;
  logic [12:0] ctrl;

  useq_scan_patch dut (.clk(clk), .rst(rst), .opcode(opcode), .cond(cond),
    .scan_sel(scan_sel), .scan_capture(scan_capture), .scan_shift(scan_shift),
    .scan_update(scan_update), .scan_in(scan_in), .scan_out(scan_out),
    .upc(upc), .ctrl(ctrl));

  always #4 clk = ~clk;

  typedef struct { logic [9:0] upc; logic [12:0] ctrl; logic so; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  logic [9:0] m_upc, m_pa;
  logic [23:0] m_uir, m_sr, m_pd;
  logic m_boot, m_pv;

  function automatic logic [23:0] rom(input logic [9:0] a);
    logic [7:0] na;
    na = a[9:2] + 8'd1;
    return {a, a[2:0] ^ 3'b101, &a[5:2], a[3:2], na};
  endfunction

  task automatic model_reset();
    m_upc = 0; m_uir = 0; m_sr = 0; m_pd = 0; m_pa = 0; m_pv = 0; m_boot = 1;
  endtask

  task automatic step(input logic [7:0] op, input logic [3:0] c, input logic cap, sh, upd,
                      input logic [1:0] sel, input logic sin, input string tag_in);
    logic [1:0] cr; logic [9:0] nxt; logic hold, upd_only; logic [23:0] nsr;
    string tag;
    tag = tag_in;
    @(negedge clk);
    rst = 0; opcode = op; cond = c; scan_capture = cap; scan_shift = sh;
    scan_update = upd; scan_sel = sel; scan_in = sin;
    case (m_uir[9:8])
      2'd0: cr = 2'b00;
      2'd1: cr = {1'b0, c[0]};
      2'd2: cr = c[1:0];
      default: cr = c[3:2];
    endcase
    nxt = m_boot ? 10'd0 : (m_uir[10] ? {2'b11, op} : {m_uir[7:0], cr});
    upd_only = upd && !cap && !sh;
    hold = upd_only && sel == 2'd0;
    nsr = m_sr;
    if (cap) begin
      case (sel)
        2'd0: nsr = m_uir;
        2'd1: nsr = {13'b0, m_pv, m_pa};
        2'd2: nsr = m_pd;
        default: nsr = 0;
      endcase
    end else if (sh) begin
      case (sel)
        2'd1: nsr = {13'b0, sin, m_sr[10:1]};
        2'd3: nsr = {23'b0, sin};
        default: nsr = {sin, m_sr[23:1]};
      endcase
    end
    if (hold) m_uir = m_sr;
    else begin
      if (!m_boot && m_uir[10]) tag = {"R4 ", tag};
      if (m_pv && nxt == m_pa) begin m_uir = m_pd; tag = {"R7 ", tag}; end
      else m_uir = rom(nxt);
      m_upc = nxt;
    end
    if (upd_only && sel == 2'd1) {m_pv, m_pa} = m_sr[10:0];
    if (upd_only && sel == 2'd2) m_pd = m_sr;
    m_sr = nsr;
    m_boot = 0;
    q.push_back('{m_upc, m_uir[23:11], m_sr[0], tag});
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++)
      step(8'h5A ^ 8'(i * 7), 4'(i * 5 + i / 3), 0, 0, 0, 0, 0, tag);
  endtask

  task automatic scan_write(input logic [1:0] sel, input logic [23:0] w, input int len, input string tag);
    for (int i = 0; i < len; i++) step(8'h33, 4'h0, 0, 1, 0, sel, w[i], tag);
    step(8'h33, 4'h0, 0, 0, 1, sel, 0, tag);
  endtask

  task automatic scan_read(input logic [1:0] sel, input int len, input string tag);
    step(8'hC4, 4'h6, 1, 0, 0, sel, 0, tag);
    for (int i = 1; i < len; i++) step(8'hC4, 4'(i), 0, 1, 0, sel, 1'b1, tag);
  endtask

  task automatic do_reset();
    repeat (2) @(negedge clk);
    rst = 1; scan_capture = 0; scan_shift = 0; scan_update = 0;
    model_reset();
    @(negedge clk);
  endtask

  task automatic chk_now(input logic cond_ok, input string what, input logic [31:0] act, exp_v);
    checks++;
    if (!cond_ok) begin
      errors++;
      $display("FAIL R1 %s actual=%h expected=%h", what, act, exp_v);
    end
  endtask

  always begin
    @(posedge clk); #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (upc !== e.upc || ctrl !== e.ctrl || scan_out !== e.so) begin
        errors++;
        $display("FAIL %s actual upc=%h ctrl=%h so=%b expected upc=%h ctrl=%h so=%b",
                 e.tag, upc, ctrl, scan_out, e.upc, e.ctrl, e.so);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk_now(upc == 0, "upc in reset", 32'(upc), 0);
    chk_now(ctrl == 0, "ctrl in reset", 32'(ctrl), 0);
    chk_now(scan_out == 0, "scan_out in reset", 32'(scan_out), 0);
    run(1, "R1");
    run(300, "R2 R3");
    scan_read(2'd0, 24, "R5 R8");
    scan_read(2'd3, 3, "R5");
    scan_read(2'd2, 6, "R5 R8");
    scan_write(2'd0, {13'h0ABC, 1'b0, 2'd2, 8'h40}, 24, "R6");
    run(4, "R6");
    scan_write(2'd2, {13'h1234, 1'b0, 2'd3, 8'h11}, 24, "R5");
    scan_write(2'd1, {13'b0, 1'b1, 10'h080}, 11, "R5");
    scan_read(2'd1, 11, "R5");
    scan_write(2'd0, {13'h0777, 1'b0, 2'd0, 8'h20}, 24, "R7");
    run(3, "R7");
    run(60, "R2 R3");
    do_reset();
    run(2, "R9");
    scan_read(2'd1, 11, "R9");
    scan_write(2'd0, {13'h0555, 1'b0, 2'd0, 8'h20}, 24, "R9");
    run(3, "R9");
    @(negedge clk);
    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule